// File: doc/BRIEF.md
# Phase-Delay Edge Timer with Frame Averaging

This block drives a square reference wave, derived by dividing the system clock, out to an external phase-shifting sensor. It then times how late the sensor's digital return rises within each reference period. The return signal is asynchronous. It is first synchronized, and the block then records the count from the start of the period to the first rising edge it sees in that period. Each such capture is stored in a small circular store that a reader can inspect, and it is also added to a running sum.

A frame strobe from the audio side closes the current frame. The block divides the frame's sum by its capture count in a sequential divider and keeps eight fractional bits. It subtracts a calibration count that marks the quarter-period zero point, and then presents the signed result with the capture count and a one-cycle valid pulse. Captures that flip between neighbouring counts therefore average to a value finer than one count. Optional pseudo-random timing dither, with an adjustable amplitude, can be added to each capture to break up slow flipping. A period with no rising edge is not captured and is tallied in a saturating miss counter.

Top module: `phase_capture_avg`

## Requirements
- R1: `ref_out` is high for the first floor(P/2) cycles of every P-cycle reference period and low for the rest, where P is `period_cfg` (values below 4 act as 4).
- R2: When `sense_in` is first sampled high at the clock edge that ends period cycle k (cycles counted from 0), with dither off, the stored capture equals k+2.
- R3: Only the first rising edge in a period is captured. A second pulse in the same period writes nothing.
- R4: Each capture is written at `buf_wptr`, and `buf_wptr` then advances by one, wrapping from DEPTH-1 (default 8 entries) to 0. `buf_data` shows the entry at `buf_addr`.
- R5: Each period that ends without a capture increments `miss_count` by one, and the counter saturates at its all-ones value (255).
- R6: A frame strobe yields one result with `res_valid` high for exactly one cycle. `res_data` = floor(sum*256/n) - cal_offset*256, taken as signed, and `res_count` = n, where sum and n cover the captures stored since the previous accepted strobe.
- R7: Captures that alternate between two adjacent counts give a result that carries the fractional part in its 8 low bits.
- R8: A frame with no captures gives `res_count` = 0 and `res_data` = -cal_offset*256.
- R9: A strobe that arrives while a division is in progress is held and served when that division ends. No capture is lost or counted twice across the frames.
- R10: When `dither_sel` = k, each capture is increased by a pseudo-random value in [0, 2^k-1] drawn from a 16-bit LFSR once per period. When k = 0 the captures are exact.
- R11: After reset, `res_valid`, `res_data`, `res_count`, `miss_count` and `buf_wptr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_cfg | input | 12 | Reference period in clock cycles |
| dither_sel | input | 3 | Number of dither bits (0 = off) |
| cal_offset | input | 12 | Zero-point count subtracted from the average |
| sense_in | input | 1 | Asynchronous return signal from the sensor |
| frame_stb | input | 1 | Closes the current frame |
| buf_addr | input | 3 | Read address into the capture store |
| ref_out | output | 1 | Square reference wave |
| buf_data | output | 12 | Capture stored at `buf_addr` |
| buf_wptr | output | 3 | Next write position of the capture store |
| miss_count | output | 8 | Saturating count of periods with no edge |
| res_data | output | 24 | Signed average, 8 fractional bits |
| res_count | output | 16 | Number of captures in the reported frame |
| res_valid | output | 1 | One-cycle result strobe |

## Verification
The case that is hardest to reach is a frame strobe that lands while the divider is still working on the previous frame. Captures keep arriving during that time, and they must be split correctly between the held frame and the one after it. The stimulus ties its pulse generator to the reference phase and issues a strobe on each of two consecutive periods, so that the second one falls inside the roughly forty-cycle division. It then closes a third frame later. The check expects exactly three results, with capture counts that add up to the number of pulses generated. Exact per-frame sums are produced the same way, by placing every sensor edge at a known offset from the observed rise of the reference.

// File: rtl/phase_capture_avg.sv
module phase_capture_avg #(
  parameter int CNT_W  = 12,
  parameter int DEPTH  = 8,
  parameter int ACC_W  = 32,
  parameter int NCNT_W = 16,
  parameter int FRAC   = 8,
  parameter int OUT_W  = 24,
  parameter int MISS_W = 8,
  parameter int DITH_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        period_cfg,
  input  logic [DITH_W-1:0]       dither_sel,
  input  logic [CNT_W-1:0]        cal_offset,
  input  logic                    sense_in,
  input  logic                    frame_stb,
  input  logic [$clog2(DEPTH)-1:0] buf_addr,
  output logic                    ref_out,
  output logic [CNT_W-1:0]        buf_data,
  output logic [$clog2(DEPTH)-1:0] buf_wptr,
  output logic [MISS_W-1:0]       miss_count,
  output logic signed [OUT_W-1:0] res_data,
  output logic [NCNT_W-1:0]       res_count,
  output logic                    res_valid
);
  localparam int AW  = $clog2(DEPTH);
  localparam int DW  = ACC_W + FRAC;
  localparam int SW  = $clog2(DW + 1);
  localparam int DMW = (1 << DITH_W) - 1;

  logic [CNT_W-1:0]  pcnt;
  logic [2:0]        sync_q;
  logic              got;
  logic [15:0]       lfsr;
  logic [DMW-1:0]    dth;
  logic [CNT_W-1:0]  mem [DEPTH];
  logic [ACC_W-1:0]  acc;
  logic [NCNT_W-1:0] ncap;
  logic              busy, pend;
  logic [SW-1:0]     step;
  logic [DW-1:0]     dvd;
  logic [NCNT_W-1:0] den, rem;

  wire [CNT_W-1:0] per_eff = (period_cfg < CNT_W'(4)) ? CNT_W'(4) : period_cfg;
  wire             last    = pcnt >= per_eff - CNT_W'(1);
  wire             rise    = sync_q[1] & ~sync_q[2];
  wire             take    = rise & ~got;
  wire [DMW-1:0]   dmask   = ~({DMW{1'b1}} << dither_sel);
  wire [CNT_W-1:0] cap_val = pcnt + CNT_W'(dth);
  wire             fin     = busy && (step == '0);
  wire             start   = (frame_stb & ~busy) | (fin & (pend | frame_stb));
  wire [NCNT_W:0]  trial   = {rem, dvd[DW-1]};
  wire             qbit    = trial >= {1'b0, den};
  wire signed [OUT_W-1:0] cal_fx =
    {{(OUT_W-CNT_W-FRAC){1'b0}}, cal_offset, {FRAC{1'b0}}};

  assign ref_out  = pcnt < (per_eff >> 1);
  assign buf_data = mem[buf_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt   <= '0;
      sync_q <= '0;
      got    <= 1'b0;
      lfsr   <= 16'hACE1;
      dth    <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sense_in};
      if (last) begin
        pcnt <= '0;
        got  <= 1'b0;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dth  <= lfsr[DMW-1:0] & dmask;
      end else begin
        pcnt <= pcnt + CNT_W'(1);
        if (take) got <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[buf_wptr] <= cap_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_wptr   <= '0;
      miss_count <= '0;
    end else begin
      if (take)
        buf_wptr <= (buf_wptr == AW'(DEPTH-1)) ? '0 : buf_wptr + AW'(1);
      if (last && !(got || take) && !(&miss_count))
        miss_count <= miss_count + MISS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      ncap <= '0;
      pend <= 1'b0;
    end else begin
      if (start) begin
        acc  <= take ? ACC_W'(cap_val) : '0;
        ncap <= take ? NCNT_W'(1) : '0;
      end else if (take && !(&ncap)) begin
        acc  <= acc + ACC_W'(cap_val);
        ncap <= ncap + NCNT_W'(1);
      end
      if (start)                 pend <= 1'b0;
      else if (frame_stb && busy) pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      dvd       <= '0;
      den       <= '0;
      rem       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_count <= '0;
    end else begin
      res_valid <= fin;
      if (fin) begin
        res_count <= den;
        res_data  <= (den == '0) ? -cal_fx : $signed(dvd[OUT_W-1:0]) - cal_fx;
      end
      if (start) begin
        busy <= 1'b1;
        step <= SW'(DW);
        dvd  <= {acc, {FRAC{1'b0}}};
        den  <= ncap;
        rem  <= '0;
      end else if (busy && step != '0) begin
        rem  <= qbit ? trial[NCNT_W-1:0] - den : trial[NCNT_W-1:0];
        dvd  <= {dvd[DW-2:0], qbit};
        step <= step - SW'(1);
      end else if (fin) begin
        busy <= 1'b0;
      end
    end
  end

  p_ref_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> ref_out);
  p_one_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last) |=> !take);
  p_wptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && buf_wptr == AW'(DEPTH-1)) |=> buf_wptr == '0);
  p_miss_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + MISS_W'(1)));
  p_miss_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&miss_count) |=> (&miss_count));
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_queue_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && busy && !fin) |=> pend);
endmodule

// File: tb/phase_capture_avg_tb_top.sv
module phase_capture_avg_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [11:0] period_cfg = 12'd20;
  logic [2:0]  dither_sel = 3'd0;
  logic [11:0] cal_offset = 12'd0;
  logic        sense_in = 1'b0;
  logic        frame_stb = 1'b0;
  logic [2:0]  buf_addr = 3'd0;
  logic        ref_out;
  logic [11:0] buf_data;
  logic [2:0]  buf_wptr;
  logic [7:0]  miss_count;
  logic signed [23:0] res_data;
  logic [15:0] res_count;
  logic        res_valid;

  phase_capture_avg dut_i (
    .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .dither_sel(dither_sel),
    .cal_offset(cal_offset), .sense_in(sense_in), .frame_stb(frame_stb),
    .buf_addr(buf_addr), .ref_out(ref_out), .buf_data(buf_data),
    .buf_wptr(buf_wptr), .miss_count(miss_count), .res_data(res_data),
    .res_count(res_count), .res_valid(res_valid)
  );

  // period, base delay, alternate, calibration, periods per frame
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{20, 3, 0, 0, 4}, '{20, 3, 1, 0, 4}, '{20, 0, 1, 2, 5},
    '{20, 7, 0, 9, 3}, '{290, 100, 1, 150, 3}, '{20, 5, 1, 0, 7}
  };

  int n_chk = 0, n_fail = 0;
  int nval = 0, last_dat = 0, last_cnt = 0, cnt_total = 0;
  int cur_p = 20, caps = 0;
  bit prev_v = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    if (rst_n && res_valid) begin
      check(!prev_v, "R6 valid lasts one cycle", 1, 0);
      nval++;
      last_dat = int'(res_data);
      last_cnt = int'(res_count);
      cnt_total += int'(res_count);
    end
    prev_v = res_valid;
  end

  task automatic sync_rise();
    while (ref_out) @(negedge clk);
    while (!ref_out) @(negedge clk);
  endtask

  task automatic one_period(input int d, input bit en, input bit stb, input bit dbl);
    for (int ph = 0; ph < cur_p; ph++) begin
      sense_in  = en && ((ph >= d && ph < d + 3) || (dbl && ph >= d + 6 && ph < d + 8));
      frame_stb = stb && (ph == cur_p - 5);
      @(negedge clk);
    end
    sense_in  = 1'b0;
    frame_stb = 1'b0;
    if (en) caps++;
  endtask

  task automatic wait_result(input int target);
    for (int i = 0; i < 600 && nval < target; i++) @(negedge clk);
  endtask

  task automatic read_entry(input int back, output int val);
    buf_addr = 3'(int'(buf_wptr) - back);
    #1;
    val = int'(buf_data);
  endtask

  task automatic clear_frame(input int p);
    int n0;
    period_cfg = 12'(p);
    cur_p = p;
    @(negedge clk);
    sync_rise();
    n0 = nval;
    one_period(2, 1, 1, 0);
    wait_result(n0 + 1);
    sync_rise();
  endtask

  initial begin
    int v, hi, n0, c0, m0;
    repeat (4) @(negedge clk);
    check(res_valid == 1'b0, "R11 res_valid", int'(res_valid), 0);
    check(res_data == '0, "R11 res_data", int'(res_data), 0);
    check(res_count == '0, "R11 res_count", int'(res_count), 0);
    check(miss_count == '0, "R11 miss_count", int'(miss_count), 0);
    check(buf_wptr == '0, "R11 buf_wptr", int'(buf_wptr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: duty and period for even and odd settings
    foreach (VEC[i]) begin end
    for (int pp = 0; pp < 2; pp++) begin
      cur_p = (pp == 0) ? 20 : 7;
      period_cfg = 12'(cur_p);
      @(negedge clk);
      sync_rise();
      sync_rise();
      hi = 0;
      for (int k = 0; k < cur_p; k++) begin
        if (ref_out) hi++;
        @(negedge clk);
      end
      check(hi == cur_p / 2, "R1 high cycles", hi, cur_p / 2);
      check(ref_out == 1'b1, "R1 period restart", int'(ref_out), 1);
    end

    // R6/R7/R2: table of frames
    for (int i = 0; i < NV; i++) begin
      int sum, n, dd, exp;
      cal_offset = 12'(VEC[i][3]);
      clear_frame(VEC[i][0]);
      sum = 0; n = 0; dd = 0;
      n0 = nval;
      for (int k = 0; k < VEC[i][4]; k++) begin
        dd = VEC[i][1] + ((VEC[i][2] != 0 && (k % 2) == 1) ? 1 : 0);
        one_period(dd, 1, k == VEC[i][4] - 1, 0);
        sum += dd + 2;
        n++;
      end
      wait_result(n0 + 1);
      exp = (sum * 256) / n - VEC[i][3] * 256;
      check(last_dat == exp, VEC[i][2] != 0 ? "R7 fractional average" : "R6 average",
            last_dat, exp);
      check(last_cnt == n, "R6 capture count", last_cnt, n);
      read_entry(1, v);
      check(v == dd + 2, "R2 capture timing", v, dd + 2);
    end
    cal_offset = 12'd0;
    check(int'(buf_wptr) == caps % 8, "R4 pointer wrap", int'(buf_wptr), caps % 8);

    // R3: two pulses in one period
    clear_frame(20);
    c0 = int'(buf_wptr);
    one_period(3, 1, 0, 1);
    read_entry(1, v);
    check(v == 5, "R3 first edge only", v, 5);
    check(int'(buf_wptr) == (c0 + 1) % 8, "R3 single write", int'(buf_wptr), (c0 + 1) % 8);

    // R10: dither on, then off
    dither_sel = 3'd3;
    one_period(2, 1, 0, 0);
    for (int k = 0; k < 8; k++) one_period(2, 1, 0, 0);
    hi = 0;
    for (int k = 1; k <= 8; k++) begin
      read_entry(k, v);
      check(v >= 4 && v <= 11, "R10 dither range", v, 4);
      if (v != 4) hi++;
    end
    check(hi > 0, "R10 dither active", hi, 1);
    dither_sel = 3'd0;
    one_period(2, 1, 0, 0);
    one_period(2, 1, 0, 0);
    read_entry(1, v);
    check(v == 4, "R10 dither off", v, 4);

    // R8: empty frame
    cal_offset = 12'd5;
    clear_frame(20);
    n0 = nval;
    one_period(0, 0, 1, 0);
    wait_result(n0 + 1);
    check(last_cnt == 0, "R8 empty count", last_cnt, 0);
    check(last_dat == -1280, "R8 empty result", last_dat, -1280);
    cal_offset = 12'd0;

    // R9: strobe during division
    clear_frame(20);
    n0 = nval;
    c0 = cnt_total;
    for (int k = 0; k < 3; k++) one_period(3, 1, k == 2, 0);
    one_period(3, 1, 1, 0);
    for (int k = 0; k < 6; k++) one_period(3, 1, k == 5, 0);
    wait_result(n0 + 3);
    repeat (100) @(negedge clk);
    check(nval - n0 == 3, "R9 results delivered", nval - n0, 3);
    check(cnt_total - c0 == 10, "R9 captures conserved", cnt_total - c0, 10);
    check(last_dat == 1280, "R9 last average", last_dat, 1280);

    // R5: miss counting and saturation
    sync_rise();
    m0 = int'(miss_count);
    for (int k = 0; k < 5; k++) one_period(0, 0, 0, 0);
    check(int'(miss_count) == m0 + 5, "R5 miss increments", int'(miss_count), m0 + 5);
    for (int k = 0; k < 260; k++) one_period(0, 0, 0, 0);
    check(miss_count == 8'hFF, "R5 saturation", int'(miss_count), 255);
    one_period(0, 0, 0, 0);
    check(miss_count == 8'hFF, "R5 stays saturated", int'(miss_count), 255);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule